// File: doc/BRIEF.md
# MSK Receive Frame Deframer

This block sits behind a minimum-shift-keyed demodulator and its clock recovery. It takes the recovered data bit together with a one-cycle strobe that marks each bit instant, and looks for a 16-bit frame sync word. Once the sync word is found, it groups the following bits into bytes. Bits are taken most significant first. Each completed byte goes to a host-visible receive register and raises an interrupt. An incoming frame is expected to contain an alternating bit-sync preamble, then the sync word, then a programmed number of payload bytes. When checksum checking is on, two checksum bytes follow the payload.

With checksum checking enabled, a CRC-16 (polynomial 0x1021, preset 0xFFFF) runs over the payload and the checksum bytes. The result appears as a flag beside the last byte in the receive data register. A frame is good when the residue is zero. Checksum checking is switched on by a bit in the transmit control register. The host is expected to collect each byte before the next one completes: within about 3.3 ms at 2400 b/s, or 6.6 ms at 1200 b/s.

The control is a three-state machine:
- HUNT: searching for the sync word.
- PAYLOAD: collecting data bytes.
- CHECKSUM: collecting the two check bytes.

The transitions are:
- sync hit: HUNT to PAYLOAD.
- payload done with checking on: PAYLOAD to CHECKSUM.
- payload done with checking off: PAYLOAD to HUNT.
- check done: CHECKSUM to HUNT.
- receiver disabled: any state to HUNT.

Top module: `msk_rx_deframer`

## Requirements
- R1: In HUNT with the receiver enabled, when the last 16 strobed bits (oldest first) equal the sync word, status bit 0 (sync seen) is set. A read of the status register (address 2) clears it.
- R2: Each group of 8 strobed bits after the sync word forms a byte, first bit in bit 7. The byte appears in bits 7:0 of the receive data register (address 3). Status bit 1 and the `irq` output are set at the same time, and a read of address 3 clears both.
- R3: The payload length is the value in bits 15:8 of the mode register (address 0). After that many bytes, with checking off, the block returns to HUNT and completes no further bytes until a new sync word arrives.
- R4: Bit 9 of the transmit control register (address 1) enables checking. Two checksum bytes are then received after the payload. Bit 8 of the receive data register is 1 on the second checksum byte only when the CRC-16 residue over payload and checksum is zero. Bit 8 is 0 on every other byte.
- R5: A byte that completes while a previous byte is still unread sets status bit 2 (overrun) and replaces the buffered byte. A status read clears the overrun bit.
- R6: Clearing bit 0 of the mode register (receiver enable) returns the block to HUNT and clears the sync-seen flag. No bytes complete while the receiver is disabled.
- R7: After reset, every register reads zero and `irq` is low.
- R8: The data bit is sampled only in cycles where `bit_stb` is high. Changes on `rx_bit` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle pulse marking a recovered bit instant |
| rx_bit | input | 1 | Demodulated data bit |
| wr_stb | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 16 | Host write data |
| rd_stb | input | 1 | Host read strobe (applies read side effects) |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Data-ready interrupt |

## Verification
The sync-seen flag, the data-ready flag, the overrun bit and the checksum flag all change on the clock edge that samples the strobed bit completing the sync word or the byte. The bench therefore holds the strobe for one cycle and samples at the falling edge that follows. Read data is combinational, so the bench samples it one step after setting the address. The clearing side effect of a read lands on the next rising edge, and the bench only observes it through the next read. A mode-register write takes effect one edge later, and the flag clear follows one edge after that. Disable checks are made only after a further read cycle.

// File: rtl/msk_deframer_pkg.sv
package msk_deframer_pkg;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_PAYLOAD  = 2'd1,
        ST_CHECKSUM = 2'd2
    } rx_state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_TXCTL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_RXDATA = 2'd3;

    localparam int MODE_EN_BIT    = 0;
    localparam int MODE_LEN_LSB   = 8;
    localparam int TXCTL_CRC_BIT  = 9;
    localparam int STAT_SYNC_BIT  = 0;
    localparam int STAT_READY_BIT = 1;
    localparam int STAT_OVR_BIT   = 2;
    localparam int RXD_CRC_BIT    = 8;

endpackage

// File: rtl/rx_sync_detect.sv
module rx_sync_detect #(
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE5B2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic bit_in,
    output logic match
);
    localparam int HIST_W = SYNC_W - 1;

    logic [HIST_W-1:0] hist_q;
    logic [SYNC_W-1:0] window;

    assign window = {hist_q, bit_in};
    assign match  = stb && !clr && (window == SYNC_WORD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (stb) begin
            hist_q <= window[HIST_W-1:0];
        end
    end

endmodule

// File: rtl/rx_byte_assembler.sv
module rx_byte_assembler #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic              bit_in,
    output logic              done,
    output logic [BYTE_W-1:0] value
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] sh_q;

    assign value = {sh_q, bit_in};
    assign done  = stb && !clr && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (stb) begin
            sh_q  <= value[BYTE_W-2:0];
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rx_crc_serial.sv
module rx_crc_serial #(
    parameter int             CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             stb,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic             feedback;

    assign feedback = crc_q[CRC_W-1] ^ bit_in;
    assign crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else if (init) begin
            crc_q <= CRC_INIT;
        end else if (stb) begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/msk_rx_deframer.sv
module msk_rx_deframer
    import msk_deframer_pkg::*;
#(
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE5B2,
    parameter int                BYTE_W    = 8,
    parameter int                REG_W     = 16,
    parameter int                CRC_W     = 16,
    parameter logic [CRC_W-1:0]  CRC_POLY  = 16'h1021,
    parameter logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rx_bit,
    input  logic              wr_stb,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_stb,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);
    localparam int LEN_W = REG_W - MODE_LEN_LSB;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    rx_state_e state_q, state_d;

    logic [REG_W-1:0]  mode_q;
    logic [REG_W-1:0]  txctl_q;
    logic              sync_flag_q;
    logic              rx_ready_q;
    logic              overrun_q;
    logic [BYTE_W-1:0] rx_byte_q;
    logic              rx_crc_ok_q;
    logic [LEN_W-1:0]  byte_cnt_q;

    logic              rx_en;
    logic              crc_en;
    logic [LEN_W-1:0]  frame_len;
    logic              in_hunt;
    logic              sync_hit;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic [CRC_W-1:0]  crc_next;
    logic              last_payload;
    logic              last_check;
    logic              wr_mode, wr_txctl, rd_status, rd_rxdata;

    assign rx_en     = mode_q[MODE_EN_BIT];
    assign frame_len = mode_q[MODE_LEN_LSB +: LEN_W];
    assign crc_en    = txctl_q[TXCTL_CRC_BIT];
    assign in_hunt   = (state_q == ST_HUNT);

    assign wr_mode   = wr_stb && (wr_addr == ADR_MODE);
    assign wr_txctl  = wr_stb && (wr_addr == ADR_TXCTL);
    assign rd_status = rd_stb && (rd_addr == ADR_STATUS);
    assign rd_rxdata = rd_stb && (rd_addr == ADR_RXDATA);

    rx_sync_detect #(
        .SYNC_W    (SYNC_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!in_hunt || !rx_en),
        .stb    (bit_stb),
        .bit_in (rx_bit),
        .match  (sync_hit)
    );

    rx_byte_assembler #(
        .BYTE_W (BYTE_W)
    ) u_bytes (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (in_hunt || !rx_en),
        .stb    (bit_stb),
        .bit_in (rx_bit),
        .done   (byte_done),
        .value  (byte_val)
    );

    rx_crc_serial #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY),
        .CRC_INIT (CRC_INIT)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (in_hunt),
        .stb      (bit_stb && rx_en),
        .bit_in   (rx_bit),
        .crc_next (crc_next)
    );

    assign last_payload = (byte_cnt_q == frame_len - LEN_ONE);
    assign last_check   = (byte_cnt_q == LEN_ONE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (sync_hit) state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (byte_done && last_payload)
                    state_d = crc_en ? ST_CHECKSUM : ST_HUNT;
            end
            ST_CHECKSUM: begin
                if (byte_done && last_check) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
        if (!rx_en) state_d = ST_HUNT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output and register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= '0;
            txctl_q     <= '0;
            sync_flag_q <= 1'b0;
            rx_ready_q  <= 1'b0;
            overrun_q   <= 1'b0;
            rx_byte_q   <= '0;
            rx_crc_ok_q <= 1'b0;
            byte_cnt_q  <= '0;
        end else begin
            if (wr_mode)  mode_q  <= wr_data;
            if (wr_txctl) txctl_q <= wr_data;

            if (sync_hit)                 sync_flag_q <= 1'b1;
            else if (!rx_en || rd_status) sync_flag_q <= 1'b0;

            if (byte_done)      rx_ready_q <= 1'b1;
            else if (rd_rxdata) rx_ready_q <= 1'b0;

            if (byte_done && rx_ready_q && !rd_rxdata) overrun_q <= 1'b1;
            else if (rd_status)                        overrun_q <= 1'b0;

            if (byte_done) begin
                rx_byte_q   <= byte_val;
                rx_crc_ok_q <= (state_q == ST_CHECKSUM) && last_check &&
                               (crc_next == '0);
            end

            if (state_d != state_q || in_hunt) begin
                byte_cnt_q <= '0;
            end else if (byte_done) begin
                byte_cnt_q <= byte_cnt_q + LEN_ONE;
            end
        end
    end

    // Host read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_MODE:   rd_data = mode_q;
            ADR_TXCTL:  rd_data = txctl_q;
            ADR_STATUS: begin
                rd_data[STAT_SYNC_BIT]  = sync_flag_q;
                rd_data[STAT_READY_BIT] = rx_ready_q;
                rd_data[STAT_OVR_BIT]   = overrun_q;
            end
            ADR_RXDATA: begin
                rd_data[BYTE_W-1:0]  = rx_byte_q;
                rd_data[RXD_CRC_BIT] = rx_crc_ok_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign irq = rx_ready_q;

    AST_SYNC_ENTERS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_flag_q) |-> (state_q == ST_PAYLOAD)); // R1
    AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready_q) |-> ($past(state_q) != ST_HUNT)); // R2
    AST_CRC_OK_AT_CHECKSUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_crc_ok_q) |-> ($past(state_q) == ST_CHECKSUM)); // R4
    AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_q) |-> $past(rx_ready_q)); // R5
    AST_DISABLE_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_q == ST_HUNT)); // R6

endmodule

// File: tb/msk_rx_deframer_test.sv
module msk_rx_deframer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SYNC = 16'hE5B2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic        rx_bit = 1'b0;
    logic        wr_stb = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msk_rx_deframer uut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; rx_bit = ~b;   // R8: off-strobe changes
        @(negedge clk);
        rx_bit = b;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_head();
        for (int i = 0; i < 8; i++) begin send_bit(1'b0); send_bit(1'b1); end
        for (int i = 15; i >= 0; i--) send_bit(SYNC[i]);
    endtask

    task automatic bwr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a; rd_stb = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    function automatic logic [15:0] crc_feed(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 37 + i * 91 + 5) & 8'hFF);
    endfunction

    task automatic rx_and_check(input logic [7:0] b, input logic good);
        logic [15:0] v;
        send_byte(b);
        chk("R2 irq after byte", int'(irq), 1);
        brd(2'd3, v);
        chk("R2 byte value", int'(v[7:0]), int'(b));
        chk("R4 checksum flag", int'(v[8]), int'(good));
        chk("R2 irq cleared by read", int'(irq), 0);
    endtask

    task automatic run_frame(input int len, input bit crc_on, input bit corrupt);
        logic [15:0] v;
        logic [15:0] crc = 16'hFFFF;
        bwr(2'd0, {8'(len), 8'h01});
        bwr(2'd1, crc_on ? 16'h0200 : 16'h0000);
        send_head();
        brd(2'd2, v);
        chk("R1 sync flag set", int'(v[0]), 1);
        brd(2'd2, v);
        chk("R1 sync flag cleared by read", int'(v[0]), 0);
        for (int i = 0; i < len; i++) begin
            crc = crc_feed(crc, pat(len, i));
            rx_and_check(pat(len, i), 1'b0);
        end
        if (crc_on) begin
            logic [15:0] c = crc ^ (corrupt ? 16'h0001 : 16'h0000);
            rx_and_check(c[15:8], 1'b0);
            rx_and_check(c[7:0], !corrupt);
        end
        send_byte(8'h00);
        chk("R3 no byte after frame end", int'(irq), 0);
        brd(2'd2, v);
        chk("R5 no overrun when read in time", int'(v[2]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state
        chk("R7 irq low", int'(irq), 0);
        brd(2'd0, v); chk("R7 mode reg", int'(v), 0);
        brd(2'd2, v); chk("R7 status reg", int'(v), 0);
        brd(2'd3, v); chk("R7 rx data reg", int'(v), 0);

        // Sweep: lengths 1..4, checking off/on, good/bad checksum
        for (int len = 1; len <= 4; len++) begin
            run_frame(len, 1'b0, 1'b0);
            run_frame(len, 1'b1, 1'b0);
            run_frame(len, 1'b1, 1'b1);
        end

        // R5 overrun
        bwr(2'd0, 16'h0201);
        bwr(2'd1, 16'h0000);
        send_head();
        send_byte(8'h5A);
        send_byte(8'hC3);
        brd(2'd2, v);
        chk("R5 overrun set", int'(v[2]), 1);
        brd(2'd3, v);
        chk("R5 newer byte kept", int'(v[7:0]), 8'hC3);
        brd(2'd2, v);
        chk("R5 overrun cleared by status read", int'(v[2]), 0);

        // R6 disable mid-frame
        bwr(2'd0, 16'h0301);
        send_head();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bwr(2'd0, 16'h0300);
        brd(2'd2, v);
        chk("R6 sync flag cleared on disable", int'(v[0]), 0);
        for (int i = 0; i < 12; i++) send_bit(i[0]);
        chk("R6 no byte while disabled", int'(irq), 0);

        // R8 strobe gating
        bwr(2'd0, 16'h0101);
        send_head();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rx_bit = ~rx_bit;
        end
        chk("R8 no byte from unstrobed toggles", int'(irq), 0);
        send_byte(8'h96);
        brd(2'd3, v);
        chk("R8 byte from strobed bits only", int'(v[7:0]), 8'h96);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule